// File: doc/BRIEF.md
# Moving Inversions Memory Tester

This block is a hardware sequencer that exercises an external synchronous RAM of 4096 words by 12 bits with the moving-inversions algorithm. One sequence has four phases. It first fills every word with a background pattern, walking upward. It then walks upward again, reading each word, checking it and writing back its complement. Next it walks downward from the top address to zero, reading, checking and restoring the original pattern. A final upward walk only reads and checks. When a sequence completes, a 16-bit pass counter advances and the pattern rotates one bit to the left before the next sequence begins.

The tester runs only when the test-request input is high at the moment reset is released. From then on it loops until the next reset, whatever the request input does. If the request is low at reset release, the tester stays idle and never drives a memory cycle. The first data mismatch sets a sticky error flag and freezes the failing address, the expected word and the observed word until reset. Testing carries on after an error, and the pass counter keeps counting.

Top module: `mvinv_tester`

## Requirements
- R1: After reset, `err_o` is 0, `pass_cnt_o` is 0 and `mem_en_o` is 0. If `test_req_i` was 0 when reset was released, `active_o` stays 0 and `mem_en_o` is never asserted.
- R2: `test_req_i` is used only while reset is high, and the value it holds in the last reset cycle selects the mode. Changing it after reset has no effect, and once running the tester stays active until reset.
- R3: Each sequence opens with a fill phase that writes the current pattern to every address, walking upward from 0 to the top address.
- R4: The upward pass handles addresses 0 to the top in order. For each address it issues a read and then a write of the bitwise complement of the pattern.
- R5: The downward pass handles addresses from the top down to 0, decrementing. For each address it issues a read and then a write of the original pattern.
- R6: The verify pass reads every address, walking upward from 0 to the top, and writes nothing.
- R7: The first sequence uses pattern 0x001. Each later sequence uses the previous pattern rotated left by one bit, so the second uses 0x002 and the third 0x004. `pass_cnt_o` increments by exactly one as each sequence ends.
- R8: Read data arrives on `mem_rdata_i` in the cycle after the read is issued and is registered before the comparison. The expected word is the pattern in the upward and verify passes and its complement in the downward pass. A mismatch sets `err_o` and records the address, the expected word and the observed word.
- R9: Only the first mismatch is recorded. The error outputs then stay frozen until reset, while bus traffic and the pass counter continue.
- R10: When a mismatch occurs on the final check of a sequence, the error capture and the pass-counter increment both take effect on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_req_i | input | 1 | Test request, sampled during reset |
| mem_en_o | output | 1 | Memory cycle enable |
| mem_we_o | output | 1 | Write (1) or read (0) when enabled |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data, valid one cycle after the read |
| active_o | output | 1 | Tester is running |
| err_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | 12 | Address of the first mismatch |
| err_exp_o | output | 12 | Expected word at the first mismatch |
| err_got_o | output | 12 | Observed word at the first mismatch |
| pass_cnt_o | output | 16 | Completed sequence count |

## Verification
Error capture and the end-of-sequence step (counter increment and pattern rotation) coincide when the mismatch falls on the last verify read at the top address. The bench forces this case with a RAM model that flips bit 0 on the third read of the top address after reset, which is the verify read of the first sequence. It then checks that `err_o` and the count of 1 first appear in the same sample, with a zero count in the sample just before. A second injected fault, in the downward pass of the next sequence, must leave the frozen record unchanged.

// File: rtl/mvinv_pkg.sv
package mvinv_pkg;

    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_UP   = 2'd1,
        PH_DN   = 2'd2,
        PH_VER  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CAPT  = 2'd2,
        ST_CHECK = 2'd3
    } step_e;

    function automatic phase_e phase_next(input phase_e p);
        case (p)
            PH_FILL: return PH_UP;
            PH_UP:   return PH_DN;
            PH_DN:   return PH_VER;
            default: return PH_FILL;
        endcase
    endfunction

    function automatic logic phase_descends(input phase_e p);
        return p == PH_DN;
    endfunction

    // Phases whose check step also writes back
    function automatic logic phase_writes(input phase_e p);
        return p != PH_VER;
    endfunction

    function automatic logic phase_expect_inv(input phase_e p);
        return p == PH_DN;
    endfunction

    function automatic logic phase_write_inv(input phase_e p);
        return p == PH_UP;
    endfunction

endpackage

// File: rtl/mvinv_addr_gen.sv
module mvinv_addr_gen #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              cur_down,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_down ? TOP : '0;
        end else if (step) begin
            addr_q <= cur_down ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr   = addr_q;
    assign at_end = cur_down ? (addr_q == '0) : (addr_q == TOP);
endmodule

// File: rtl/mvinv_seq.sv
module mvinv_seq
    import mvinv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_req,
    input  logic   at_end,
    output logic   running,
    output phase_e phase,
    output logic   bus_en,
    output logic   bus_we,
    output logic   capture,
    output logic   chk_en,
    output logic   seq_done,
    output logic   ag_load,
    output logic   ag_load_down,
    output logic   ag_step,
    output logic   ag_down
);
    logic   run_q;
    step_e  st_q;
    phase_e ph_q;
    logic   fill_wr;
    logic   advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= start_req;
            st_q  <= ST_IDLE;
            ph_q  <= PH_FILL;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (run_q) st_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (ph_q != PH_FILL) st_q <= ST_CAPT;
                    else if (at_end)     ph_q <= phase_next(ph_q);
                end
                ST_CAPT: begin
                    st_q <= ST_CHECK;
                end
                default: begin
                    st_q <= ST_ISSUE;
                    if (at_end) ph_q <= phase_next(ph_q);
                end
            endcase
        end
    end

    always_comb begin
        fill_wr      = (st_q == ST_ISSUE) && (ph_q == PH_FILL);
        advance      = fill_wr || (st_q == ST_CHECK);
        ag_load      = advance && at_end;
        ag_step      = advance && !at_end;
        ag_load_down = phase_descends(phase_next(ph_q));
        ag_down      = phase_descends(ph_q);
        bus_en       = (st_q == ST_ISSUE) || ((st_q == ST_CHECK) && phase_writes(ph_q));
        bus_we       = fill_wr || ((st_q == ST_CHECK) && phase_writes(ph_q));
        capture      = (st_q == ST_CAPT);
        chk_en       = (st_q == ST_CHECK);
        seq_done     = (st_q == ST_CHECK) && (ph_q == PH_VER) && at_end;
    end

    assign running = (st_q != ST_IDLE);
    assign phase   = ph_q;
endmodule

// File: rtl/mvinv_err_latch.sv
module mvinv_err_latch #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] exp_d,
    input  logic [DATA_W-1:0] got_d,
    output logic              flag,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_exp,
    output logic [DATA_W-1:0] rec_got
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp_d;
        logic [DATA_W-1:0] got_d;
    } err_rec_t;

    logic     flag_q;
    err_rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            rec_q  <= '0;
        end else if (hit && !flag_q) begin
            flag_q <= 1'b1;
            rec_q  <= '{addr: addr, exp_d: exp_d, got_d: got_d};
        end
    end

    assign flag     = flag_q;
    assign rec_addr = rec_q.addr;
    assign rec_exp  = rec_q.exp_d;
    assign rec_got  = rec_q.got_d;
endmodule

// File: rtl/mvinv_tester.sv
module mvinv_tester
    import mvinv_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 12,
    parameter int              PASS_W   = 16,
    parameter logic [DATA_W-1:0] INIT_PAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_req_i,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              active_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [DATA_W-1:0] err_exp_o,
    output logic [DATA_W-1:0] err_got_o,
    output logic [PASS_W-1:0] pass_cnt_o
);
    phase_e            phase;
    logic              capture, chk_en, seq_done;
    logic              ag_load, ag_load_down, ag_step, ag_down, at_end;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] pat_q, rd_q, exp_w;
    logic [PASS_W-1:0] pass_q;
    logic              mismatch;

    mvinv_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_req    (test_req_i),
        .at_end       (at_end),
        .running      (active_o),
        .phase        (phase),
        .bus_en       (mem_en_o),
        .bus_we       (mem_we_o),
        .capture      (capture),
        .chk_en       (chk_en),
        .seq_done     (seq_done),
        .ag_load      (ag_load),
        .ag_load_down (ag_load_down),
        .ag_step      (ag_step),
        .ag_down      (ag_down)
    );

    mvinv_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .cur_down  (ag_down),
        .addr      (addr),
        .at_end    (at_end)
    );

    // Pattern, pass count and registered read data
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q  <= INIT_PAT;
            pass_q <= '0;
            rd_q   <= '0;
        end else begin
            if (capture) rd_q <= mem_rdata_i;
            if (seq_done) begin
                pat_q  <= {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
                pass_q <= pass_q + 1'b1;
            end
        end
    end

    assign exp_w    = phase_expect_inv(phase) ? ~pat_q : pat_q;
    assign mismatch = chk_en && (rd_q != exp_w);

    mvinv_err_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_err (
        .clk      (clk),
        .rst      (rst),
        .hit      (mismatch),
        .addr     (addr),
        .exp_d    (exp_w),
        .got_d    (rd_q),
        .flag     (err_o),
        .rec_addr (err_addr_o),
        .rec_exp  (err_exp_o),
        .rec_got  (err_got_o)
    );

    assign mem_addr_o  = addr;
    assign mem_wdata_o = phase_write_inv(phase) ? ~pat_q : pat_q;
    assign pass_cnt_o  = pass_q;
endmodule

// File: rtl/mvinv_checker.sv
module mvinv_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 12,
    parameter int PASS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              active_o,
    input logic              mem_en_o,
    input logic              mem_we_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] err_addr_o,
    input logic [DATA_W-1:0] err_exp_o,
    input logic [DATA_W-1:0] err_got_o,
    input logic [PASS_W-1:0] pass_cnt_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> !mem_en_o);

    p_stay_active_r2: assert property (@(posedge clk) disable iff (rst)
        active_o |=> active_o);

    p_pass_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(pass_cnt_o) |-> pass_cnt_o == PASS_W'($past(pass_cnt_o) + 1'b1));

    p_err_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(mem_en_o && !mem_we_o, 3));

    p_err_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o && $stable(err_addr_o) && $stable(err_exp_o) && $stable(err_got_o));
endmodule

bind mvinv_tester mvinv_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .active_o   (active_o),
    .mem_en_o   (mem_en_o),
    .mem_we_o   (mem_we_o),
    .err_o      (err_o),
    .err_addr_o (err_addr_o),
    .err_exp_o  (err_exp_o),
    .err_got_o  (err_got_o),
    .pass_cnt_o (pass_cnt_o)
);

// File: tb/mvinv_tester_bench.sv
module mvinv_tester_bench;
    localparam int AW = 5;
    localparam int DW = 12;
    localparam int PW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          test_req = 1'b0;
    logic          mem_en, mem_we, active, err;
    logic [AW-1:0] mem_addr, err_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_got;
    logic [PW-1:0] pass_cnt;

    always #5 clk = ~clk;

    mvinv_tester #(.ADDR_W(AW), .DATA_W(DW), .PASS_W(PW)) u_mvinv_tester (
        .clk         (clk),
        .rst         (rst),
        .test_req_i  (test_req),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .active_o    (active),
        .err_o       (err),
        .err_addr_o  (err_addr),
        .err_exp_o   (err_exp),
        .err_got_o   (err_got),
        .pass_cnt_o  (pass_cnt)
    );

    // RAM model with read-fault injection
    logic [DW-1:0] mem [N];
    logic          fault_on = 1'b0;
    int            f1_cnt, f2_cnt;
    localparam int F1_ADDR = N - 1;  // 3rd read: verify pass, sequence 1
    localparam int F2_ADDR = 3;      // 5th read: downward pass, sequence 2

    always_ff @(posedge clk) begin
        if (rst) begin
            f1_cnt <= 0;
            f2_cnt <= 0;
        end else if (mem_en && mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end else if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            if (int'(mem_addr) == F1_ADDR) begin
                f1_cnt <= f1_cnt + 1;
                if (fault_on && f1_cnt == 2) mem_rdata <= mem[mem_addr] ^ 12'h001;
            end
            if (int'(mem_addr) == F2_ADDR) begin
                f2_cnt <= f2_cnt + 1;
                if (fault_on && f2_cnt == 4) mem_rdata <= mem[mem_addr] ^ 12'h001;
            end
        end
    end

    int tests = 0;
    int fails = 0;
    int ops_seen = 0;
    bit done = 1'b0;

    // Scoreboard queues
    int            qa [$];
    bit            qw [$];
    logic [DW-1:0] qd [$];
    string         qt [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input int a, input bit w, input logic [DW-1:0] d, input string t);
        qa.push_back(a); qw.push_back(w); qd.push_back(d); qt.push_back(t);
    endtask

    task automatic push_seq(input logic [DW-1:0] p);
        for (int a = 0; a < N; a++) push(a, 1'b1, p, "R3");
        for (int a = 0; a < N; a++) begin
            push(a, 1'b0, '0, "R4");
            push(a, 1'b1, ~p, "R4");
        end
        for (int a = N - 1; a >= 0; a--) begin
            push(a, 1'b0, '0, "R5");
            push(a, 1'b1, p, "R5");
        end
        for (int a = 0; a < N; a++) push(a, 1'b0, '0, "R6");
    endtask

    // Monitor: pops and compares every bus cycle
    always @(negedge clk) begin
        if (!rst && mem_en && !done) begin
            ops_seen++;
            if (qa.size() == 0) begin
                check(1'b0, "R1", "unexpected bus cycle addr", longint'(mem_addr), 0);
            end else begin
                automatic int            ea = qa.pop_front();
                automatic bit            ew = qw.pop_front();
                automatic logic [DW-1:0] ed = qd.pop_front();
                automatic string         et = qt.pop_front();
                check(int'(mem_addr) == ea, et, "address", longint'(mem_addr), longint'(ea));
                check(mem_we == ew, et, "write enable", longint'(mem_we), longint'(ew));
                if (ew) check(mem_wdata == ed, et, "write data", longint'(mem_wdata), longint'(ed));
            end
        end
    end

    task automatic do_reset(input bit req);
        @(negedge clk);
        rst = 1'b1;
        test_req = req;
        qa.delete(); qw.delete(); qd.delete(); qt.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ops_seen = 0;
    endtask

    task automatic wait_pass(input int n, input string req);
        int c = 0;
        while (int'(pass_cnt) < n && c < 20000) begin
            @(negedge clk);
            c++;
        end
        if (c >= 20000) check(1'b0, req, "watchdog waiting for pass count", longint'(pass_cnt), n);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // Run 1: no request at reset; raising it later must be ignored
        do_reset(1'b0);
        check(err == 1'b0, "R1", "reset err_o", longint'(err), 0);
        check(pass_cnt == '0, "R1", "reset pass count", longint'(pass_cnt), 0);
        check(mem_en == 1'b0, "R1", "reset mem_en_o", longint'(mem_en), 0);
        test_req = 1'b1;
        repeat (60) @(negedge clk);
        check(active == 1'b0, "R2", "late request active_o", longint'(active), 0);
        check(ops_seen == 0, "R1", "idle bus cycles", longint'(ops_seen), 0);

        // Run 2: clean memory, request dropped right after reset
        do_reset(1'b1);
        push_seq(12'h001); push_seq(12'h002); push_seq(12'h004);
        test_req = 1'b0;
        repeat (5) @(negedge clk);
        check(active == 1'b1, "R2", "running after request drop", longint'(active), 1);
        wait_pass(2, "R7");
        check(pass_cnt == 16'd2, "R7", "pass count after two sequences", longint'(pass_cnt), 2);
        check(ops_seen == 2 * 6 * N, "R7", "bus cycles in two sequences", longint'(ops_seen), 2 * 6 * N);
        check(err == 1'b0, "R8", "no error on clean memory", longint'(err), 0);
        check(active == 1'b1, "R2", "still looping", longint'(active), 1);

        // Run 3: faults; first lands on last verify read (R10)
        fault_on = 1'b1;
        do_reset(1'b1);
        push_seq(12'h001); push_seq(12'h002); push_seq(12'h004); push_seq(12'h008);
        begin
            int c = 0;
            bit prev_err = 1'b0;
            int prev_pass = 0;
            while (!err && c < 20000) begin
                prev_err = err;
                prev_pass = int'(pass_cnt);
                @(negedge clk);
                c++;
            end
            check(c < 20000, "R8", "error flag raised", longint'(err), 1);
            check(prev_err == 1'b0 && prev_pass == 0, "R10", "pass count before error",
                  longint'(prev_pass), 0);
            check(pass_cnt == 16'd1, "R10", "pass count in error cycle", longint'(pass_cnt), 1);
        end
        check(int'(err_addr) == N - 1, "R8", "error address", longint'(err_addr), N - 1);
        check(err_exp == 12'h001, "R8", "error expected word", longint'(err_exp), 12'h001);
        check(err_got == 12'h000, "R8", "error observed word", longint'(err_got), 12'h000);
        wait_pass(3, "R9");
        check(f2_cnt >= 5, "R9", "second fault was reached", longint'(f2_cnt), 5);
        check(int'(err_addr) == N - 1, "R9", "frozen error address", longint'(err_addr), N - 1);
        check(err_exp == 12'h001, "R9", "frozen expected word", longint'(err_exp), 12'h001);
        check(err_got == 12'h000, "R9", "frozen observed word", longint'(err_got), 12'h000);
        check(err == 1'b1, "R9", "error flag held", longint'(err), 1);
        check(active == 1'b1, "R9", "testing continues after error", longint'(active), 1);

        finish_up();
    end
endmodule